// File: doc/BRIEF.md
# DDR SDRAM Read Burst Sequencer

This block is the read-side timing engine of a double-data-rate SDRAM device model. It takes decoded Read commands, each with a bank, a starting column and an auto-precharge flag. It then schedules the data-out stream against a programmed CAS latency, burst length and burst ordering. For every clock cycle it produces two element slots: one for the rising half of the cycle and one for the falling half. Each slot carries the column index of the element driven in that half. Alongside the slots it gives a DQ output enable, a DQS drive enable and the DQS level for each half. The DQS output includes the low preamble and postamble cycles around each burst.

A new Read may arrive on any cycle. When it arrives while a burst is in flight, the old burst stops after the pairs already due and the new burst follows at once. When it arrives exactly at the end of the old burst, the two bursts join into one continuous stream. When it arrives later than that, the strobe closes with a postamble and reopens with a fresh preamble. A per-bank row-active timer, loaded by each Activate, holds back the auto-precharge request until the minimum row-active time has passed.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, dqs_oe_o, dq_oe_o, dqs_rise_o, dqs_fall_o and every bit of ap_req_o are 0.
- R2: A Read sampled at a rising edge delivers its first data pair in the cycle that begins cfg_cas_lat_i rising edges later. Supported latencies are 2 up to MAX_CL.
- R3: cfg_burst_len_i code 1, 2 or 3 selects 2, 4 or 8 elements. The burst lasts that many elements divided by two cycles, with element 2k in the rise slot and element 2k+1 in the fall slot of the k-th data cycle.
- R4: In every data cycle dq_oe_o=1, dqs_oe_o=1, dqs_rise_o=1 and dqs_fall_o=0.
- R5: The cycle before the first data cycle of a burst that does not directly follow a data cycle is a preamble: dqs_oe_o=1, dq_oe_o=0 and both DQS slots are 0.
- R6: The cycle after a data cycle that no data cycle follows is a postamble: dqs_oe_o=1, dq_oe_o=0 and both DQS slots are 0. After it, dqs_oe_o drops to 0 unless a preamble is due.
- R7: With cfg_interleave_i=0, element e has column index {start column above the burst block, (start offset + e) mod burst length}.
- R8: With cfg_interleave_i=1, element e has the low bits (start offset XOR e). The bits above the burst block are unchanged.
- R9: A Read sampled x cycles after the previous Read, where x is smaller than that burst's pair count, truncates the old burst after x data pairs. The new burst's data follows with no gap, no postamble and no preamble.
- R10: A Read sampled exactly pair-count cycles after the previous one concatenates the two bursts into an unbroken data stream.
- R11: A Read sampled two or more cycles after the previous burst's natural end produces a postamble, at least one cycle with dqs_oe_o=0, and then a preamble.
- R12: A burst issued with rd_ap_i=1 that runs to its last pair raises ap_req_o[bank] for exactly one cycle. That cycle is the one after its last data cycle if the bank's row-active counter has expired. Otherwise it is the first cycle in which the counter reaches zero, which is cfg_tras_i cycles after the Activate edge.
- R13: A burst issued with rd_ap_i=0 never raises ap_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat_i | input | CL_W | CAS latency in cycles |
| cfg_burst_len_i | input | 2 | Burst length code: 1=2, 2=4, 3=8 elements |
| cfg_interleave_i | input | 1 | 0 sequential, 1 interleaved element order |
| cfg_tras_i | input | TRAS_W | Minimum row-active time in cycles |
| act_i | input | 1 | Activate command strobe |
| act_bank_i | input | BANK_W | Bank of the Activate |
| rd_i | input | 1 | Read command strobe |
| rd_bank_i | input | BANK_W | Bank of the Read |
| rd_col_i | input | COL_W | Starting column of the Read |
| rd_ap_i | input | 1 | Auto-precharge flag of the Read |
| dqs_oe_o | output | 1 | DQS drive enable |
| dqs_rise_o | output | 1 | DQS level in the rising half-cycle |
| dqs_fall_o | output | 1 | DQS level in the falling half-cycle |
| dq_oe_o | output | 1 | DQ drive enable (data valid) |
| col_rise_o | output | COL_W | Column index of the rising-half element |
| col_fall_o | output | COL_W | Column index of the falling-half element |
| ap_req_o | output | NB | Per-bank auto-precharge request pulse |

## Verification
Single isolated Reads are run at latencies 2, 3 and 4, with every burst length and both orderings. Their start offsets are chosen so that wrap-around shows up, which separates latency errors from ordering errors. Read pairs are then spaced below, at, and beyond the first burst's pair count. These cases separate truncation, seamless concatenation and the postamble/idle/preamble gap by the exact cycles of strobe enable and column index. Auto-precharge is tried once with the row-active counter expired and once with it still running, and a Read without the flag is also tried. This shows whether the request waits for the counter or for the end of the burst.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  parameter int unsigned COL_W  = 10;
  parameter int unsigned BANK_W = 2;
  parameter int unsigned ELEM_W = 3;           // log2 of longest burst
  parameter int unsigned PAIR_W = ELEM_W - 1;

  typedef struct packed {
    logic              vld;
    logic              ap;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } rd_cmd_t;

  localparam logic [1:0] BL_CODE_4 = 2'd2;
  localparam logic [1:0] BL_CODE_8 = 2'd3;
endpackage

// File: rtl/ddr_rd_cmd_delay.sv
module ddr_rd_cmd_delay
  import ddr_rd_pkg::*;
#(
  parameter int unsigned MAX_CL = 4,
  parameter int unsigned CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  rd_cmd_t         cmd_i,
  input  logic [CL_W-1:0] cl_i,
  output rd_cmd_t         tap_o
);
  rd_cmd_t [MAX_CL-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[MAX_CL-2:0], cmd_i};
  end

  // stage cl-1 feeds the engine, so data appears after cl edges
  always_comb begin
    tap_o = '0;
    for (int i = 0; i < MAX_CL; i++)
      if (cl_i == CL_W'(i + 1)) tap_o = pipe_q[i];
  end
endmodule

// File: rtl/ddr_rd_col_gen.sv
module ddr_rd_col_gen
  import ddr_rd_pkg::*;
(
  input  logic [COL_W-1:0]  base_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic [1:0]        bl_i,
  input  logic              interleave_i,
  output logic [COL_W-1:0]  col_rise_o,
  output logic [COL_W-1:0]  col_fall_o
);
  localparam int unsigned HI_W = COL_W - ELEM_W;

  logic [ELEM_W-1:0] mask;
  logic [1:0][COL_W-1:0] col;

  always_comb begin
    unique case (bl_i)
      BL_CODE_4: mask = 3'b011;
      BL_CODE_8: mask = 3'b111;
      default:   mask = 3'b001;
    endcase
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [ELEM_W-1:0] elem, off, wrap;
    assign elem = {pair_i, 1'(s)};
    assign off  = base_i[ELEM_W-1:0] & mask;
    assign wrap = (interleave_i ? (off ^ elem) : (off + elem)) & mask;
    assign col[s] = (base_i & ~{{HI_W{1'b0}}, mask}) | {{HI_W{1'b0}}, wrap};
  end

  assign col_rise_o = col[0];
  assign col_fall_o = col[1];
endmodule

// File: rtl/ddr_rd_burst_engine.sv
module ddr_rd_burst_engine
  import ddr_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_cmd_t           tap_i,
  input  logic [1:0]        bl_i,
  input  logic              interleave_i,
  output logic              dqs_oe_o,
  output logic              dqs_rise_o,
  output logic              dqs_fall_o,
  output logic              dq_oe_o,
  output logic [COL_W-1:0]  col_rise_o,
  output logic [COL_W-1:0]  col_fall_o,
  output logic              done_o,
  output logic [BANK_W-1:0] done_bank_o
);
  logic              active_q, post_q, ap_q;
  logic [PAIR_W-1:0] pair_q, last_pair;
  logic [COL_W-1:0]  base_q;
  logic [BANK_W-1:0] bank_q;
  logic              at_last;

  always_comb begin
    unique case (bl_i)
      BL_CODE_4: last_pair = PAIR_W'(1);
      BL_CODE_8: last_pair = PAIR_W'(3);
      default:   last_pair = '0;
    endcase
  end

  assign at_last = active_q && (pair_q == last_pair);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      post_q   <= 1'b0;
      ap_q     <= 1'b0;
      pair_q   <= '0;
      base_q   <= '0;
      bank_q   <= '0;
    end else begin
      post_q <= at_last && !tap_i.vld;
      if (tap_i.vld) begin
        // a new burst restarts the engine: truncation or concatenation
        active_q <= 1'b1;
        pair_q   <= '0;
        base_q   <= tap_i.col;
        bank_q   <= tap_i.bank;
        ap_q     <= tap_i.ap;
      end else if (at_last) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        pair_q <= pair_q + PAIR_W'(1);
      end
    end
  end

  ddr_rd_col_gen u_col_gen (
    .base_i       (base_q),
    .pair_i       (pair_q),
    .bl_i         (bl_i),
    .interleave_i (interleave_i),
    .col_rise_o   (col_rise_o),
    .col_fall_o   (col_fall_o)
  );

  // tap valid while idle marks the preamble cycle
  assign dqs_oe_o    = active_q || post_q || tap_i.vld;
  assign dqs_rise_o  = active_q;
  assign dqs_fall_o  = 1'b0;
  assign dq_oe_o     = active_q;
  assign done_o      = at_last && ap_q;
  assign done_bank_o = bank_q;
endmodule

// File: rtl/ddr_rd_ap_timer.sv
module ddr_rd_ap_timer
  import ddr_rd_pkg::*;
#(
  parameter int unsigned TRAS_W = 6,
  parameter int unsigned NB     = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [TRAS_W-1:0] tras_i,
  input  logic              done_i,
  input  logic [BANK_W-1:0] done_bank_i,
  output logic [NB-1:0]     ap_req_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [TRAS_W-1:0] cnt_q;
    logic              pend_q;
    logic              req;

    assign req         = pend_q && (cnt_q == '0);
    assign ap_req_o[b] = req;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        if (act_i && act_bank_i == BANK_W'(b)) cnt_q <= tras_i;
        else if (cnt_q != '0)                  cnt_q <= cnt_q - TRAS_W'(1);
        if (done_i && done_bank_i == BANK_W'(b)) pend_q <= 1'b1;
        else if (req)                            pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
  import ddr_rd_pkg::*;
#(
  parameter int unsigned MAX_CL = 4,
  parameter int unsigned TRAS_W = 6,
  parameter int unsigned CL_W   = $clog2(MAX_CL + 1),
  parameter int unsigned NB     = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CL_W-1:0]   cfg_cas_lat_i,
  input  logic [1:0]        cfg_burst_len_i,
  input  logic              cfg_interleave_i,
  input  logic [TRAS_W-1:0] cfg_tras_i,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [COL_W-1:0]  rd_col_i,
  input  logic              rd_ap_i,
  output logic              dqs_oe_o,
  output logic              dqs_rise_o,
  output logic              dqs_fall_o,
  output logic              dq_oe_o,
  output logic [COL_W-1:0]  col_rise_o,
  output logic [COL_W-1:0]  col_fall_o,
  output logic [NB-1:0]     ap_req_o
);
  rd_cmd_t           cmd, tap;
  logic              done;
  logic [BANK_W-1:0] done_bank;

  assign cmd = '{vld: rd_i, ap: rd_ap_i, bank: rd_bank_i, col: rd_col_i};

  ddr_rd_cmd_delay #(.MAX_CL(MAX_CL), .CL_W(CL_W)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .cl_i   (cfg_cas_lat_i),
    .tap_o  (tap)
  );

  ddr_rd_burst_engine u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tap_i        (tap),
    .bl_i         (cfg_burst_len_i),
    .interleave_i (cfg_interleave_i),
    .dqs_oe_o     (dqs_oe_o),
    .dqs_rise_o   (dqs_rise_o),
    .dqs_fall_o   (dqs_fall_o),
    .dq_oe_o      (dq_oe_o),
    .col_rise_o   (col_rise_o),
    .col_fall_o   (col_fall_o),
    .done_o       (done),
    .done_bank_o  (done_bank)
  );

  ddr_rd_ap_timer #(.TRAS_W(TRAS_W), .NB(NB)) u_ap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_i),
    .act_bank_i  (act_bank_i),
    .tras_i      (cfg_tras_i),
    .done_i      (done),
    .done_bank_i (done_bank),
    .ap_req_o    (ap_req_o)
  );
endmodule

// File: rtl/ddr_rd_burst_seq_chk.sv
module ddr_rd_burst_seq_chk #(
  parameter int unsigned NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dqs_oe_o,
  input logic          dqs_rise_o,
  input logic          dqs_fall_o,
  input logic          dq_oe_o,
  input logic [NB-1:0] ap_req_o
);
  AST_DATA_HAS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_oe_o); // R4
  AST_DATA_STROBE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_rise_o && !dqs_fall_o)); // R4
  AST_QUIET_STROBE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_o && !dq_oe_o) |-> (!dqs_rise_o && !dqs_fall_o)); // R5
  AST_PREAMBLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(dqs_oe_o)); // R5
  AST_POSTAMBLE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> dqs_oe_o); // R6
  AST_AP_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ap_req_o) |-> ((ap_req_o & $past(ap_req_o)) == '0)); // R12
endmodule

bind ddr_rd_burst_seq ddr_rd_burst_seq_chk #(.NB(NB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dqs_oe_o   (dqs_oe_o),
  .dqs_rise_o (dqs_rise_o),
  .dqs_fall_o (dqs_fall_o),
  .dq_oe_o    (dq_oe_o),
  .ap_req_o   (ap_req_o)
);

// File: tb/ddr_rd_burst_seq_bench.sv
`timescale 1ns/1ps
module ddr_rd_burst_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cfg_cas_lat_i = 3'd2;
  logic [1:0] cfg_burst_len_i = 2'd2;
  logic       cfg_interleave_i = 1'b0;
  logic [5:0] cfg_tras_i = 6'd0;
  logic       act_i = 1'b0;
  logic [1:0] act_bank_i = '0;
  logic       rd_i = 1'b0;
  logic [1:0] rd_bank_i = '0;
  logic [9:0] rd_col_i = '0;
  logic       rd_ap_i = 1'b0;
  logic       dqs_oe_o, dqs_rise_o, dqs_fall_o, dq_oe_o;
  logic [9:0] col_rise_o, col_fall_o;
  logic [3:0] ap_req_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ddr_rd_burst_seq u_ddr_rd_burst_seq (.*);

  // drive one cycle of inputs, then land on the next negedge
  task automatic step(bit rd = 0, logic [9:0] col = '0, logic [1:0] bank = '0,
                      bit ap = 0, bit act = 0, logic [1:0] abank = '0);
    rd_i = rd; rd_col_i = col; rd_bank_i = bank; rd_ap_i = ap;
    act_i = act; act_bank_i = abank;
    @(negedge clk_i);
    rd_i = 1'b0; act_i = 1'b0;
  endtask

  task automatic chk(string req, bit e_dqs, bit e_dq,
                     logic [9:0] e_cr = '0, logic [9:0] e_cf = '0);
    logic [3:0] act_v, exp_v;
    bit bad;
    n_run++;
    act_v = {dqs_oe_o, dq_oe_o, dqs_rise_o, dqs_fall_o};
    exp_v = {e_dqs, e_dq, e_dq, 1'b0};
    bad = (act_v != exp_v) || (e_dq && (col_rise_o != e_cr || col_fall_o != e_cf));
    if (bad) begin
      n_fail++;
      $display("FAIL %s: oe/dq/rise/fall=%b cols=%0d,%0d expected %b cols=%0d,%0d",
               req, act_v, col_rise_o, col_fall_o, exp_v, e_cr, e_cf);
    end
  endtask

  task automatic chk_ap(string req, logic [3:0] e);
    n_run++;
    if (ap_req_o !== e) begin
      n_fail++;
      $display("FAIL %s: ap_req=%b expected %b", req, ap_req_o, e);
    end
  endtask

  task automatic cfg(int cl, int bl, bit il);
    cfg_cas_lat_i = 3'(cl); cfg_burst_len_i = 2'(bl); cfg_interleave_i = il;
  endtask

  task automatic t_reset();
    chk("R1 reset", 0, 0);
    chk_ap("R1 reset ap", 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", 0, 0);
  endtask

  // BL4, CL2, sequential from column 5
  task automatic t_single_seq();
    cfg(2, 2, 0);
    step(1, 10'd5);       chk("R2 no early strobe", 0, 0);
    step();               chk("R5 preamble", 1, 0);
    step();               chk("R7 R3 pair0 seq wrap", 1, 1, 10'd5, 10'd6);
    step();               chk("R7 R4 pair1 seq wrap", 1, 1, 10'd7, 10'd4);
    step();               chk("R6 postamble", 1, 0);
    step();               chk("R6 hi-z after postamble", 0, 0);
    chk_ap("R13 no ap request", 4'b0000);
  endtask

  // BL8, CL3, interleaved from column 10
  task automatic t_single_il();
    cfg(3, 3, 1);
    step(1, 10'd10);      chk("R2 cl3 idle", 0, 0);
    step();               chk("R2 cl3 still idle", 0, 0);
    step();               chk("R5 cl3 preamble", 1, 0);
    step();               chk("R8 pair0", 1, 1, 10'd10, 10'd11);
    step();               chk("R8 pair1", 1, 1, 10'd8,  10'd9);
    step();               chk("R8 pair2", 1, 1, 10'd14, 10'd15);
    step();               chk("R8 R3 pair3", 1, 1, 10'd12, 10'd13);
    step();               chk("R6 cl3 postamble", 1, 0);
    step();
  endtask

  // BL2, CL4, sequential from column 3
  task automatic t_bl2_cl4();
    cfg(4, 1, 0);
    step(1, 10'd3);
    step();
    step();               chk("R2 cl4 idle", 0, 0);
    step();               chk("R5 cl4 preamble", 1, 0);
    step();               chk("R3 R7 bl2 pair", 1, 1, 10'd3, 10'd2);
    step();               chk("R3 bl2 ends after one pair", 1, 0);
    step();
  endtask

  // BL8 CL2: second read two cycles later truncates
  task automatic t_truncate();
    cfg(2, 3, 0);
    step(1, 10'd0);
    step();               chk("R9 preamble", 1, 0);
    step(1, 10'd16);      chk("R9 old pair0", 1, 1, 10'd0, 10'd1);
    step();               chk("R9 old pair1", 1, 1, 10'd2, 10'd3);
    step();               chk("R9 new pair0 no gap", 1, 1, 10'd16, 10'd17);
    step();               chk("R9 new pair1", 1, 1, 10'd18, 10'd19);
    step();               chk("R9 new pair2", 1, 1, 10'd20, 10'd21);
    step();               chk("R9 new pair3", 1, 1, 10'd22, 10'd23);
    step();               chk("R9 postamble", 1, 0);
    step();               chk("R9 idle", 0, 0);
  endtask

  // BL4 CL2: second read exactly two cycles later concatenates
  task automatic t_concat();
    cfg(2, 2, 0);
    step(1, 10'd0);
    step();               chk("R10 preamble", 1, 0);
    step(1, 10'd8);       chk("R10 a0", 1, 1, 10'd0, 10'd1);
    step();               chk("R10 a1", 1, 1, 10'd2, 10'd3);
    step();               chk("R10 b0 seamless", 1, 1, 10'd8, 10'd9);
    step();               chk("R10 b1", 1, 1, 10'd10, 10'd11);
    step();               chk("R10 postamble", 1, 0);
    step();               chk("R10 idle", 0, 0);
  endtask

  // BL2 CL2: second read leaves an idle cycle
  task automatic t_gap();
    cfg(2, 1, 0);
    step(1, 10'd3);
    step();               chk("R11 preamble a", 1, 0);
    step();               chk("R11 data a", 1, 1, 10'd3, 10'd2);
    step();               chk("R11 postamble a", 1, 0);
    step(1, 10'd6);       chk("R11 hi-z between", 0, 0);
    step();               chk("R11 preamble b", 1, 0);
    step();               chk("R11 data b", 1, 1, 10'd6, 10'd7);
    step();               chk("R11 postamble b", 1, 0);
    step();
  endtask

  task automatic t_ap_ready();
    cfg(2, 1, 0);
    cfg_tras_i = 6'd2;
    step(0, '0, '0, 0, 1, 2'd2);
    step(1, 10'd4, 2'd2, 1);
    step();
    step();               chk("R12 data", 1, 1, 10'd4, 10'd5);
                          chk_ap("R12 not before burst end", 4'b0000);
    step();               chk_ap("R12 request after burst", 4'b0100);
    step();               chk_ap("R12 single cycle", 4'b0000);
  endtask

  task automatic t_ap_wait();
    cfg(2, 1, 0);
    cfg_tras_i = 6'd20;
    step(0, '0, '0, 0, 1, 2'd1);           // after step 0
    step(1, 10'd0, 2'd1, 1);               // after step 1
    for (int k = 2; k < 20; k++) begin
      step();
      if (k == 4 || k == 19) chk_ap("R12 held by tRAS", 4'b0000);
    end
    step();               chk_ap("R12 request at tRAS expiry", 4'b0010);
    step();               chk_ap("R12 pulse ends", 4'b0000);
    step(1, 10'd0, 2'd1, 0);
    for (int k = 0; k < 6; k++) begin
      step();
      if (ap_req_o != 4'b0000) chk_ap("R13 no flag no request", 4'b0000);
    end
    chk_ap("R13 no flag no request", 4'b0000);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_single_seq();
    t_single_il();
    t_bl2_cl4();
    t_truncate();
    t_concat();
    t_gap();
    t_ap_ready();
    t_ap_wait();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule